// File: doc/BRIEF.md
# Stream Descrambler with Lock Tracking

This block recovers plain bits from a scrambled 100 Mb/s twisted-pair line stream, one bit per enabled clock. The cipher is an 11-bit linear feedback shift register with the polynomial x^11 + x^9 + 1. The block needs no seed from outside. While it is unlocked, it assumes that the line carries idle (all ones). It loads its register with the inverted received bits and checks each new bit against the bit that the register predicts. Thirty matches in a row declare lock. From then on the register runs freely and removes the cipher from every bit.

While locked, the block watches a symbol-error strobe during valid frames. A long unbroken run of errors means that lock is lost. When that happens, the block drops the lock flag, wipes its cipher state and starts acquisition again. In the two modes that carry no cipher, bits pass straight through and the block stays unlocked.

Top module: `stream_descrambler`

## Requirements
- R1: While `rstN` is low, `locked` and `bitOut` read 0 after the next clock edge, and the cipher state and all counters are cleared.
- R2: `mode` is encoded 2'b00 = scrambled twisted-pair, 2'b01 = fiber, 2'b10 = 10 Mb/s, 2'b11 = reserved. The last three are bypass modes. In a bypass mode, every enabled bit appears unchanged on `bitOut` one edge later, `locked` is 0 and the cipher state is cleared.
- R3: On an edge where `bitValid` is low, `bitOut`, `locked` and all internal state hold, whatever the other inputs do, `mode` included.
- R4: When unlocked in mode 2'b00, the block predicts the key bit as register bit 11 XOR bit 9. It shifts the inverted received bit into the register. `locked` rises on the edge of the 30th consecutive enabled bit whose inverted value equals the prediction.
- R5: A prediction mismatch during acquisition restarts the match count from zero, so 29 matches followed by a miss do not lock.
- R6: In mode 2'b00, `bitOut` equals the received bit XOR the key bit, one edge later. Once locked, the register shifts in its own key bit each enabled bit, so a correctly scrambled stream comes out as its plain bits.
- R7: Once locked, lock is kept through idle gaps of any length, 5 bits included, and through any stretch where `rxDv` is low. Only a qualifying error run or a mode change can clear it.
- R8: While locked, an enabled bit with `rxDv` and `codeErr` both high extends the consecutive-error count. The 65th such bit in a row clears `locked` and the cipher state on its edge, and acquisition begins anew. Runs of 64 errors keep lock.
- R9: An enabled bit with `codeErr` low, or with `rxDv` low, sets the consecutive-error count back to zero.
- R10: After a loss of lock, a fresh idle run re-acquires lock, and data after that descrambles correctly again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| bitValid | input | 1 | Enable: one received line bit is present on this edge |
| bitIn | input | 1 | Received scrambled bit |
| rxDv | input | 1 | High while a frame is being received |
| codeErr | input | 1 | High when the current symbol is an invalid code |
| mode | input | 2 | 00 twisted-pair with cipher, 01 fiber, 10 10 Mb/s, 11 reserved (bypass) |
| bitOut | output | 1 | Descrambled (or passed-through) bit, registered |
| locked | output | 1 | Cipher state is synchronized |

## Verification
The hardest state to reach is the boundary of the error run while locked. The bench has to hold lock first, then bring the consecutive-error count to exactly 64. It must also show that a clean bit or a dropped `rxDv` restarts the count before the 65th error finally breaks lock. Directed sequences do this from a known locked state. They then prove acquisition again from the wiped register. The prediction-restart rule is reached on purpose by flipping one bit inside an idle run that is too short to lock. Random segments of idle runs, frames, error bursts and disabled cycles with toggled mode then run against a bench model derived from the requirements.

// File: rtl/descr_pkg.sv
package descr_pkg;

  typedef enum logic [1:0] {
    MODE_TX  = 2'b00,
    MODE_FX  = 2'b01,
    MODE_10T = 2'b10,
    MODE_RSV = 2'b11
  } phyMode_e;

  // strobes from control to datapath, acted on only with bitValid
  typedef struct packed {
    logic bypass;   // pass bit through, clear register
    logic acquire;  // shift inverted received bit
    logic track;    // shift own key bit
    logic wipe;     // clear register after loss of lock
  } dpCtl_t;

endpackage

// File: rtl/descr_datapath.sv
module descr_datapath
  import descr_pkg::*;
#(
  parameter int LFSR_W = 11,
  parameter int TAP_HI = 11,
  parameter int TAP_LO = 9
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   bitValid,
  input  logic   bitIn,
  input  dpCtl_t ctl,
  output logic   keyBit,
  output logic   bitOut
);

  localparam int HI_IDX = TAP_HI - 1;
  localparam int LO_IDX = TAP_LO - 1;

  logic [LFSR_W-1:0] lfsr;
  logic [LFSR_W-1:0] lfsrNext;

  assign keyBit = lfsr[HI_IDX] ^ lfsr[LO_IDX];

  always_comb begin
    lfsrNext = lfsr;
    if (ctl.bypass || ctl.wipe) begin
      lfsrNext = '0;
    end else if (ctl.acquire) begin
      lfsrNext = {lfsr[LFSR_W-2:0], ~bitIn};
    end else if (ctl.track) begin
      lfsrNext = {lfsr[LFSR_W-2:0], keyBit};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr   <= '0;
      bitOut <= 1'b0;
    end else if (bitValid) begin
      lfsr   <= lfsrNext;
      bitOut <= ctl.bypass ? bitIn : (bitIn ^ keyBit);
    end
  end

endmodule

// File: rtl/descr_control.sv
module descr_control
  import descr_pkg::*;
#(
  parameter int LOCK_RUN  = 30,
  parameter int ERR_LIMIT = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitValid,
  input  logic       bitIn,
  input  logic       keyBit,
  input  logic       rxDv,
  input  logic       codeErr,
  input  logic [1:0] mode,
  output dpCtl_t     ctl,
  output logic       locked
);

  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam int ERR_W = $clog2(ERR_LIMIT + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);
  localparam logic [ERR_W-1:0] ERR_TOP  = ERR_W'(ERR_LIMIT);

  logic [RUN_W-1:0] runCnt;
  logic [ERR_W-1:0] errCnt;
  logic isTx, match, errHit, lossNow;

  assign isTx    = (mode == MODE_TX);
  assign match   = (keyBit == ~bitIn);
  assign errHit  = rxDv && codeErr;
  assign lossNow = isTx && locked && errHit && (errCnt == ERR_TOP);

  assign ctl.bypass  = !isTx;
  assign ctl.acquire = isTx && !locked;
  assign ctl.track   = isTx && locked && !lossNow;
  assign ctl.wipe    = lossNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked <= 1'b0;
      runCnt <= '0;
      errCnt <= '0;
    end else if (bitValid) begin
      if (!isTx) begin
        locked <= 1'b0;
        runCnt <= '0;
        errCnt <= '0;
      end else if (!locked) begin
        errCnt <= '0;
        if (!match) begin
          runCnt <= '0;
        end else if (runCnt == RUN_LAST) begin
          locked <= 1'b1;
          runCnt <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end else if (!errHit) begin
        errCnt <= '0;
      end else if (lossNow) begin
        locked <= 1'b0;
        errCnt <= '0;
        runCnt <= '0;
      end else begin
        errCnt <= errCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/stream_descrambler.sv
module stream_descrambler
  import descr_pkg::*;
#(
  parameter int LFSR_W    = 11,
  parameter int TAP_HI    = 11,
  parameter int TAP_LO    = 9,
  parameter int LOCK_RUN  = 30,
  parameter int ERR_LIMIT = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitValid,
  input  logic       bitIn,
  input  logic       rxDv,
  input  logic       codeErr,
  input  logic [1:0] mode,
  output logic       bitOut,
  output logic       locked
);

  dpCtl_t dpCtl;
  logic   keyBit;

  descr_control #(
    .LOCK_RUN (LOCK_RUN),
    .ERR_LIMIT(ERR_LIMIT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bitValid(bitValid),
    .bitIn   (bitIn),
    .keyBit  (keyBit),
    .rxDv    (rxDv),
    .codeErr (codeErr),
    .mode    (mode),
    .ctl     (dpCtl),
    .locked  (locked)
  );

  descr_datapath #(
    .LFSR_W(LFSR_W),
    .TAP_HI(TAP_HI),
    .TAP_LO(TAP_LO)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .bitValid(bitValid),
    .bitIn   (bitIn),
    .ctl     (dpCtl),
    .keyBit  (keyBit),
    .bitOut  (bitOut)
  );

endmodule

// File: rtl/stream_descrambler_checker.sv
module stream_descrambler_checker (
  input logic       clk,
  input logic       rstN,
  input logic       bitValid,
  input logic       bitIn,
  input logic       rxDv,
  input logic       codeErr,
  input logic [1:0] mode,
  input logic       bitOut,
  input logic       locked
);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |=> $stable(bitOut) && $stable(locked));

  p_bypass_r2: assert property (@(posedge clk) disable iff (!rstN)
    bitValid && (mode != 2'b00) |=> (bitOut == $past(bitIn)) && !locked);

  p_keep_lock_r7: assert property (@(posedge clk) disable iff (!rstN)
    locked && (mode == 2'b00) && !(rxDv && codeErr) |=> locked);

  p_lock_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(bitValid) && ($past(mode) == 2'b00));

  p_drop_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $past(bitValid) &&
                      (($past(mode) != 2'b00) || $past(rxDv && codeErr)));

endmodule

bind stream_descrambler stream_descrambler_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .bitValid(bitValid),
  .bitIn   (bitIn),
  .rxDv    (rxDv),
  .codeErr (codeErr),
  .mode    (mode),
  .bitOut  (bitOut),
  .locked  (locked)
);

// File: tb/stream_descrambler_bench.sv
module stream_descrambler_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitValid = 1'b0;
  logic       bitIn = 1'b0;
  logic       rxDv = 1'b0;
  logic       codeErr = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       bitOut;
  logic       locked;

  int nChk = 0;
  int nErr = 0;

  // bench reference state, built from the requirements
  logic [10:0] refReg = '0;
  int          refRun = 0;
  int          refErrs = 0;
  logic        refLock = 1'b0;
  logic        refOut = 1'b0;
  logic [10:0] txReg = 11'h5A3;

  always #10 clk = ~clk;

  stream_descrambler u_stream_descrambler (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .rxDv(rxDv), .codeErr(codeErr), .mode(mode),
    .bitOut(bitOut), .locked(locked)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  function automatic logic keyOf(input logic [10:0] r);
    return r[10] ^ r[8];
  endfunction

  task automatic refStep(input logic b, input logic dv, input logic err);
    logic k;
    if (mode != 2'b00) begin
      refOut = b; refLock = 1'b0; refReg = '0; refRun = 0; refErrs = 0;
    end else begin
      k = keyOf(refReg);
      refOut = b ^ k;
      if (!refLock) begin
        refErrs = 0;
        if (k == ~b) refRun++; else refRun = 0;
        refReg = {refReg[9:0], ~b};
        if (refRun >= 30) begin refLock = 1'b1; refRun = 0; end
      end else begin
        refReg = {refReg[9:0], k};
        if (dv && err) begin
          if (refErrs == 64) begin
            refLock = 1'b0; refReg = '0; refErrs = 0; refRun = 0;
          end else refErrs++;
        end else refErrs = 0;
      end
    end
  endtask

  task automatic sendBit(input logic b, input logic dv, input logic err, input string tag);
    @(negedge clk);
    bitIn = b; bitValid = 1'b1; rxDv = dv; codeErr = err;
    refStep(b, dv, err);
    @(posedge clk); #1;
    check(tag, "bitOut", bitOut, refOut);
    check(tag, "locked", locked, refLock);
    @(negedge clk);
    bitValid = 1'b0;
  endtask

  // scramble a plain bit with the bench transmitter and send it
  task automatic txSend(input logic plain, input logic dv, input logic err,
                        input string tag, input logic wantPlain);
    logic k;
    k = keyOf(txReg);
    txReg = {txReg[9:0], k};
    sendBit(plain ^ k, dv, err, tag);
    if (wantPlain) check(tag, "plain", bitOut, plain);
  endtask

  // disabled cycles with noise on every other input, mode included
  task automatic gapCycles(input int n);
    logic [1:0] keepMode;
    keepMode = mode;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bitValid = 1'b0;
      bitIn = 1'($urandom); rxDv = 1'($urandom); codeErr = 1'($urandom);
      mode = 2'($urandom);
      @(posedge clk); #1;
      check("R3", "bitOut", bitOut, refOut);
      check("R3", "locked", locked, refLock);
    end
    @(negedge clk);
    mode = keepMode;
  endtask

  initial begin : watchdog
    #(20 * 150000);
    nErr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin : stimulus
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    check("R1", "locked", locked, 1'b0);
    check("R1", "bitOut", bitOut, 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    // R2: bypass modes
    mode = 2'b01;
    for (int i = 0; i < 20; i++) sendBit(1'($urandom), 1'b1, 1'($urandom), "R2");
    mode = 2'b10;
    for (int i = 0; i < 12; i++) sendBit(1'($urandom), 1'b0, 1'b0, "R2");
    mode = 2'b11;
    for (int i = 0; i < 8; i++) sendBit(1'($urandom), 1'b1, 1'b0, "R2");
    gapCycles(6);

    // R5: miss inside a short idle run prevents lock
    mode = 2'b00;
    for (int i = 0; i < 22; i++) txSend(1'b1, 1'b0, 1'b0, "R5", 1'b0);
    txSend(1'b0, 1'b0, 1'b0, "R5", 1'b0);
    for (int i = 0; i < 20; i++) txSend(1'b1, 1'b0, 1'b0, "R5", 1'b0);
    check("R5", "locked", locked, 1'b0);

    // R4: a long idle run locks
    for (int i = 0; i < 50; i++) txSend(1'b1, 1'b0, 1'b0, "R4", 1'b0);
    check("R4", "locked", locked, 1'b1);

    // R6: frame data descrambles
    for (int i = 0; i < 40; i++) txSend(1'($urandom), 1'b1, 1'b0, "R6", 1'b1);
    // R7: 5-bit gap, then another frame
    for (int i = 0; i < 5; i++) txSend(1'b1, 1'b0, 1'b0, "R7", 1'b1);
    gapCycles(4);
    for (int i = 0; i < 30; i++) txSend(1'($urandom), 1'b1, 1'b0, "R7", 1'b1);
    check("R7", "locked", locked, 1'b1);

    // R8 / R9: error runs up to the limit
    for (int i = 0; i < 64; i++) txSend(1'($urandom), 1'b1, 1'b1, "R8", 1'b1);
    check("R8", "locked", locked, 1'b1);
    txSend(1'($urandom), 1'b1, 1'b0, "R9", 1'b1);
    for (int i = 0; i < 64; i++) txSend(1'($urandom), 1'b1, 1'b1, "R9", 1'b1);
    txSend(1'b1, 1'b0, 1'b1, "R9", 1'b1);
    for (int i = 0; i < 64; i++) txSend(1'($urandom), 1'b1, 1'b1, "R9", 1'b1);
    check("R9", "locked", locked, 1'b1);
    txSend(1'($urandom), 1'b1, 1'b1, "R8", 1'b0);
    check("R8", "locked", locked, 1'b0);

    // R10: re-acquire and descramble again
    for (int i = 0; i < 60; i++) txSend(1'b1, 1'b0, 1'b0, "R10", 1'b0);
    check("R10", "locked", locked, 1'b1);
    for (int i = 0; i < 20; i++) txSend(1'($urandom), 1'b1, 1'b0, "R10", 1'b1);

    // random segments against the bench model
    for (int s = 0; s < 60; s++) begin
      case ($urandom % 4)
        0: for (int i = 0; i < 20 + int'($urandom % 41); i++)
             txSend(1'b1, 1'b0, 1'b0, "R4", 1'b0);
        1: for (int i = 0; i < 10 + int'($urandom % 41); i++)
             txSend(1'($urandom), 1'b1, 1'(($urandom % 8) == 0), "R6", 1'b0);
        2: for (int i = 0; i < 50 + int'($urandom % 31); i++)
             txSend(1'($urandom), 1'b1, 1'b1, "R8", 1'b0);
        default: gapCycles(1 + int'($urandom % 5));
      endcase
    end

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

endmodule